// File: doc/BRIEF.md
# Byte-Serial Hamming Parity Generator for Flash Data Chunks

This block builds a 24-bit single-error-correcting, double-error-detecting parity code over a chunk of data that arrives one byte per clock. With each byte the sender presents the byte's position within the chunk. The block keeps two kinds of parity. Row parities come in pairs and are steered by the bits of that position. Column parities are steered by bit position inside the byte. Because of this layout, the XOR of a stored code and a recomputed code points straight at the failing byte and bit.

The chunk size is chosen per chunk: 256 bytes or 512 bytes. A flash page larger than one chunk is covered by running the block once for each 512-byte chunk, so each chunk gets its own three-byte code. When the byte at index zero is accepted, the accumulators restart, so no separate clear input is needed. A one-cycle strobe marks the cycle in which the finished code is first visible. The code then stays unchanged until the next chunk starts.

Top module: `nand_parity_gen`

## Requirements
- R1: After reset, `done` is 0 and `code` is 24'h030000: all parity is zero, the chunk size is 256 bytes, and bits 17:16 are forced to 1.
- R2: For each index bit k in 0..7, the XOR of all eight bits of an accepted byte is folded into row parity 2k+1 when index bit k is 1, and into row parity 2k when it is 0. Row parities 7..0 appear on `code[7:0]` and row parities 15..8 on `code[15:8]`, with the higher-numbered parity in the more significant bit.
- R3: In 512-byte mode, index bit 8 steers the byte parity in the same way into row parity 17 (bit 8 is 1), shown on `code[17]`, or row parity 16 (bit 8 is 0), shown on `code[16]`. A single flipped data bit then changes exactly 12 code bits. The byte address is {code[17],code[15],code[13],...,code[1]} and the bit address is {code[23],code[21],code[19]}.
- R4: Column parities are accumulated over every accepted byte and placed on `code[23:18]` as follows, from the most significant bit down:
  - bits 7..4 of the byte;
  - bits 3..0;
  - bits 7,6,3,2;
  - bits 5,4,1,0;
  - bits 7,5,3,1;
  - bits 6,4,2,0.
- R5: The code is packed as three bytes: byte 0 is `code[7:0]`, byte 1 is `code[15:8]`, and byte 2 is `code[23:16]`. For example, byte 8'hBA accepted alone at index 0 in 256-byte mode gives 24'h975555.
- R6: When a chunk is started with `size_512` low, `code[17:16]` reads 2'b11 for the whole chunk.
- R7: A cycle with `en` low changes neither `code` nor `done`, whatever `byte_in` and `idx` carry.
- R8: Accepting a byte at index 0 discards all earlier parity and latches the chunk size from `size_512`. This also applies when it interrupts a chunk that is still in progress.
- R9: `done` is high for exactly the one cycle after the byte with the final index has been accepted (255 in 256-byte mode, 511 in 512-byte mode). It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Byte valid; the byte is accepted on a rising edge while high |
| size_512 | input | 1 | Chunk size selector, sampled with the index-0 byte: 1 = 512 bytes, 0 = 256 bytes |
| byte_in | input | 8 | Data byte |
| idx | input | 9 | Position of the byte within the chunk |
| code | output | 24 | Accumulated parity code, three packed bytes |
| done | output | 1 | One-cycle strobe after the final byte of a chunk is accepted |

## Verification
A byte accepted on a rising edge updates `code` in the same edge, so the new value is due one cycle after the byte is presented. `done` rises one cycle after the final-index byte is presented and falls one cycle later. Reset release takes two further edges to reach the registers. The bench drives and samples on falling edges, and each task checks `code` and `done` at the falling edge that follows the edge on which they change. Checks that an idle byte is ignored, and that the code is held after a chunk ends, read `code` across the idle cycles before the next accepted byte.

// File: rtl/nand_parity_pkg.sv
package nand_parity_pkg;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = $clog2(BYTE_W);
  localparam int COL_W    = 2 * SEL_W;
  localparam int CODE_W   = 24;

  // Mask of the byte bits whose position has bit k equal to 'odd'
  function automatic logic [BYTE_W-1:0] col_mask(input int k, input logic odd);
    logic [BYTE_W-1:0] m;
    for (int b = 0; b < BYTE_W; b++) begin
      m[b] = (((b >> k) & 1) == int'(odd));
    end
    return m;
  endfunction
endpackage

// File: rtl/nand_rst_sync.sv
module nand_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/nand_row_parity.sv
module nand_row_parity #(
  parameter int IDX_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               clear,
  input  logic               row_par,
  input  logic [IDX_W-1:0]   idx,
  output logic [2*IDX_W-1:0] lp
);
  localparam int LP_W = 2 * IDX_W;

  logic [LP_W-1:0] lp_q, lp_d, base;

  assign base = clear ? '0 : lp_q;

  for (genvar k = 0; k < IDX_W; k++) begin : g_pair
    assign lp_d[2*k+1] = base[2*k+1] ^ (row_par &  idx[k]);
    assign lp_d[2*k]   = base[2*k]   ^ (row_par & ~idx[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lp_q <= '0;
    else if (acc_en) lp_q <= lp_d;
  end

  assign lp = lp_q;
endmodule

// File: rtl/nand_col_parity.sv
module nand_col_parity
  import nand_parity_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              clear,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [COL_W-1:0]  cp
);
  logic [COL_W-1:0] cp_q, cp_d, base;

  assign base = clear ? '0 : cp_q;

  for (genvar k = 0; k < SEL_W; k++) begin : g_sel
    assign cp_d[2*k+1] = base[2*k+1] ^ (^(byte_in & col_mask(k, 1'b1)));
    assign cp_d[2*k]   = base[2*k]   ^ (^(byte_in & col_mask(k, 1'b0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cp_q <= '0;
    else if (acc_en) cp_q <= cp_d;
  end

  assign cp = cp_q;
endmodule

// File: rtl/nand_chunk_seq.sv
module nand_chunk_seq #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             size_512,
  input  logic [IDX_W-1:0] idx,
  output logic             start,
  output logic             size_q,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_BIG   = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST_SMALL = {1'b0, {(IDX_W-1){1'b1}}};

  logic size_d, done_d, size_cur;

  always_comb begin
    start    = en && (idx == '0);
    size_cur = start ? size_512 : size_q;
    size_d   = size_cur;
    done_d   = en && (idx == (size_cur ? LAST_BIG : LAST_SMALL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= done_d;
      if (start) size_q <= size_d;
    end
  end
endmodule

// File: rtl/nand_parity_gen.sv
module nand_parity_gen
  import nand_parity_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              size_512,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [IDX_W-1:0]  idx,
  output logic [CODE_W-1:0] code,
  output logic              done
);
  localparam int LP_W = 2 * IDX_W;

  logic             rst_n_s;
  logic             start, size_q;
  logic [LP_W-1:0]  lp;
  logic [COL_W-1:0] cp;
  logic             row_par;

  assign row_par = ^byte_in;

  nand_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  nand_chunk_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .en       (en),
    .size_512 (size_512),
    .idx      (idx),
    .start    (start),
    .size_q   (size_q),
    .done     (done)
  );

  nand_row_parity #(.IDX_W(IDX_W)) u_row (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .acc_en  (en),
    .clear   (start),
    .row_par (row_par),
    .idx     (idx),
    .lp      (lp)
  );

  nand_col_parity u_col (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .acc_en  (en),
    .clear   (start),
    .byte_in (byte_in),
    .cp      (cp)
  );

  // byte 2 = {column parity, row pair 17/16}; forced high in small-chunk mode
  assign code = {cp, (size_q ? lp[17:16] : 2'b11), lp[15:0]};
endmodule

// File: rtl/nand_parity_gen_chk.sv
module nand_parity_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        size_512,
  input logic [7:0]  byte_in,
  input logic [8:0]  idx,
  input logic [23:0] code,
  input logic        done
);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(code) && !done));

  p_start_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && idx == 9'd0) |=> ((code[15:0] & 16'hAAAA) == 16'h0000));

  p_small_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && idx == 9'd0 && !size_512) |=> (code[17:16] == 2'b11));

  p_col_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && idx == 9'd0) |=> (code[23:18] == {^($past(byte_in) & 8'hF0),
                                             ^($past(byte_in) & 8'h0F),
                                             ^($past(byte_in) & 8'hCC),
                                             ^($past(byte_in) & 8'h33),
                                             ^($past(byte_in) & 8'hAA),
                                             ^($past(byte_in) & 8'h55)}));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(en));
endmodule

bind nand_parity_gen nand_parity_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .size_512 (size_512),
  .byte_in  (byte_in),
  .idx      (idx),
  .code     (code),
  .done     (done)
);

// File: tb/nand_parity_gen_tb.sv
module nand_parity_gen_tb;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic        size_512;
  logic [7:0]  byte_in;
  logic [8:0]  idx;
  logic [23:0] code;
  logic        done;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] chunk [512];

  nand_parity_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .size_512(size_512),
    .byte_in(byte_in), .idx(idx), .code(code), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic logic [23:0] model(input int n, input bit big);
    logic [17:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < n; i++) begin
      logic p = ^chunk[i];
      for (int k = 0; k < 9; k++) begin
        if ((i >> k) & 1) lp[2*k+1] ^= p;
        else              lp[2*k]   ^= p;
      end
      cp ^= {^(chunk[i] & 8'hF0), ^(chunk[i] & 8'h0F), ^(chunk[i] & 8'hCC),
             ^(chunk[i] & 8'h33), ^(chunk[i] & 8'hAA), ^(chunk[i] & 8'h55)};
    end
    if (!big) lp[17:16] = 2'b11;
    return {cp, lp};
  endfunction

  task automatic put(input logic [7:0] b, input int i, input bit big);
    @(negedge clk);
    en = 1'b1; byte_in = b; idx = 9'(i); size_512 = big;
  endtask

  task automatic idle;
    @(negedge clk);
    en = 1'b0; byte_in = 8'h5A; idx = 9'h1FF; size_512 = 1'b1;
  endtask

  // Streams a full chunk, checks done timing and the code
  task automatic run_chunk(input int n, input bit big, input string req);
    for (int i = 0; i < n; i++) begin
      put(chunk[i], i, big);
      if (i > 0) chk({req, " done low mid-chunk"}, {23'd0, done}, 24'd0);
    end
    idle;
    chk({req, " done after last"}, {23'd0, done}, 24'd1);
    chk({req, " code"}, code, model(n, big));
    idle;
    chk({req, " done one cycle"}, {23'd0, done}, 24'd0);
  endtask

  task automatic t_reset;
    en = 1'b0; size_512 = 1'b0; byte_in = '0; idx = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset code", code, 24'h030000);
    chk("R1 reset done", {23'd0, done}, 24'd0);
  endtask

  task automatic t_packing;
    put(8'hBA, 0, 1'b0);
    idle;
    chk("R5 single byte packing", code, 24'h975555);
    chk("R6 forced bits", {22'd0, code[17:16]}, 24'd3);
  endtask

  task automatic t_small_chunk;
    for (int i = 0; i < 256; i++) chunk[i] = 8'((i * 37 + 11) ^ (i >> 3));
    run_chunk(256, 1'b0, "R2 R4 R9 256-byte");
    repeat (4) idle;
    chk("R9 code held after done", code, model(256, 1'b0));
  endtask

  task automatic t_big_chunk;
    for (int i = 0; i < 512; i++) chunk[i] = 8'((i * 73) ^ (i >> 2) ^ 8'hC3);
    run_chunk(512, 1'b1, "R3 R9 512-byte");
  endtask

  task automatic t_gaps;
    logic [23:0] hold;
    for (int i = 0; i < 256; i++) chunk[i] = 8'(i ^ 8'h96);
    for (int i = 0; i < 256; i++) begin
      put(chunk[i], i, 1'b0);
      if (i % 17 == 3) begin
        idle;
        hold = code;
        idle;
        chk("R7 idle cycle ignored", code, hold);
      end
    end
    idle;
    chk("R7 gapped result", code, model(256, 1'b0));
    chk("R9 done after gapped chunk", {23'd0, done}, 24'd1);
  endtask

  task automatic t_restart;
    for (int i = 0; i < 40; i++) put(8'hFF - 8'(i), i, 1'b1);
    for (int i = 0; i < 256; i++) chunk[i] = 8'(i * 5);
    run_chunk(256, 1'b0, "R8 restart mid-chunk");
  endtask

  task automatic t_syndrome;
    logic [23:0] good, bad, syn;
    logic [8:0]  baddr;
    for (int i = 0; i < 512; i++) chunk[i] = 8'((i * 29) + 7);
    run_chunk(512, 1'b1, "R3 syndrome base");
    good = code;
    chunk[300] ^= 8'h20;
    run_chunk(512, 1'b1, "R3 syndrome flip");
    bad = code;
    syn = good ^ bad;
    chk("R3 syndrome weight", 24'($countones(syn)), 24'd12);
    for (int k = 0; k < 9; k++) baddr[k] = syn[2*k+1];
    chk("R3 byte address", 24'(baddr), 24'd300);
    chk("R3 bit address", 24'({syn[23], syn[21], syn[19]}), 24'd5);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_packing;
        t_small_chunk;
        t_big_chunk;
        t_gaps;
        t_restart;
        t_syndrome;
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule